// File: doc/BRIEF.md
# Linked Descriptor Ring Walker

The block serves one transfer queue by following a chain of packet descriptors stored in memory. Each descriptor is 24 bytes long and sits on a 16-byte boundary. Its first byte holds flags: bit 0 means the engine owns the descriptor, bit 2 is set by the engine on a receive overrun, and bit 7 asks for a completion event. Bits 31:16 of the first word hold the receive allowance in bytes. The word at byte offset 8 holds the low word of the next-descriptor pointer and the word at offset 16 holds the low word of the buffer pointer. Bits 15:0 of the word at offset 20 hold the data length. The words at offsets 4 and 12 hold the upper pointer halves and are never read.

Software fills in a descriptor, sets the ownership bit and pulses `start` with the address of the first descriptor. The engine then reads each owned descriptor and moves its data. In transmit mode it reads the buffer and sends it out as a word stream. In receive mode it writes an incoming word stream into the buffer. After that it hands the descriptor back and follows the next pointer. When it reads a descriptor it does not own, it stops and keeps that address. A later `resume` reads the same descriptor again. The memory port carries 32-bit words, and read data returns one cycle after the request.

Top module: `ring_walker`

## Requirements
- R1: While and directly after reset, `idle` is 1 and `mem_req`, `tx_valid`, `rx_ready`, `done` and `empty` are 0.
- R2: A `start` pulse in the idle state loads the start address with its low 4 bits forced to zero and latches `rx_mode`. Every memory access is word aligned.
- R3: A descriptor whose flag bit 0 reads as 0 is not modified. It produces a one-cycle `empty` pulse, after which `idle` is 1. A `resume` pulse then fetches that same descriptor again.
- R4: In transmit mode the engine emits ceil(length/4) words, read from consecutive buffer words in order, on `tx_data` with `tx_valid`. `tx_last` is set only on the final word. A length of 0 emits nothing.
- R5: On completion the engine rewrites word 0 of the descriptor. Flag bit 0 is cleared, the other flag bits are kept, byte 1 is written as zero and the allowance in bits 31:16 is unchanged.
- R6: `done` pulses once for each completed descriptor that has flag bit 7 set, and never for one that has it clear.
- R7: After a descriptor completes, the engine goes on to the next-pointer word with its low 4 bits ignored.
- R8: In receive mode each accepted word is stored at the next buffer word. When the word flagged `rx_last` has been taken, the received byte count (4 per word) is written to bits 15:0 of the word at offset 20, with bits 31:16 written as zero. This happens before word 0 is handed back.
- R9: Receive data beyond the allowance A is truncated. Word k is stored only when 4k < A. The stored length is min(4·words, A), and flag bit 2 is set exactly when 4·words > A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking at `start_addr` (used only when idle) |
| resume | input | 1 | Re-fetch the held descriptor (used only when idle) |
| start_addr | input | 32 | Byte address of the first descriptor |
| rx_mode | input | 1 | 1 = receive, 0 = transmit, latched on `start` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of a descriptor |
| rx_valid | input | 1 | Receive word offered |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Final word of a packet |
| rx_ready | output | 1 | Engine accepts receive words |
| done | output | 1 | Completion pulse for descriptors that request it |
| empty | output | 1 | Pulse when an unowned descriptor is reached |
| idle | output | 1 | Engine stopped |

## Verification
Each descriptor takes four request/response pairs, so 8 cycles pass before data moves. `empty` rises in the cycle after the flag-word request, and `idle` follows one cycle later. A transmit word appears in the cycle after its buffer read. The write of the length word and the flags write each take one cycle after the last receive word. The bench drives inputs and samples outputs on falling edges only. It waits for `idle` before it inspects memory, and it counts stream words, `done` pulses and `empty` pulses as they occur. As a result, no check depends on guessing the exact cycle of a completion. The sweeps cover every transmit length from 0 to 12 and every pairing of allowance 0 to 12 with 1 to 4 receive words.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 16;
    localparam int FLG_OWN  = 0;
    localparam int FLG_OVR  = 2;
    localparam int FLG_IRQ  = 7;
    localparam logic [AW-1:0] ALIGN_MASK = 32'hFFFF_FFF0;
    localparam logic [4:0] OFF_LEN = 5'd20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CATCH, ST_TXRD,
        ST_TXOUT, ST_RXIN, ST_PUTLEN, ST_PUTFLG
    } walk_st_e;

    typedef struct packed {
        logic [LW-1:0] allow;
        logic [7:0]    flags;
        logic [AW-1:0] next;
        logic [AW-1:0] bufp;
        logic [LW-1:0] len;
    } desc_t;

    // byte offset of the k-th descriptor word that the engine reads
    function automatic logic [4:0] field_off(input logic [1:0] k);
        case (k)
            2'd0:    return 5'd0;
            2'd1:    return 5'd8;
            2'd2:    return 5'd16;
            default: return OFF_LEN;
        endcase
    endfunction

    function automatic logic [LW-1:0] word_count(input logic [LW-1:0] len);
        return LW'((32'(len) + 32'd3) >> 2);
    endfunction
endpackage

// File: rtl/ring_walk_rx_acc.sv
module ring_walk_rx_acc
    import ring_walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  logic [LW-1:0] allow,
    output logic [LW-1:0] count,
    output logic          trunc,
    output logic          room
);
    logic [LW:0] grown;
    logic        over;

    assign room  = count < allow;
    assign grown = {1'b0, count} + (LW+1)'(4);
    assign over  = grown > {1'b0, allow};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            trunc <= 1'b0;
        end else if (take) begin
            if (room) count <= over ? allow : grown[LW-1:0];
            if (over) trunc <= 1'b1;
        end
    end

    p_count_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        $past(take) |-> count <= allow);
endmodule

// File: rtl/ring_walk_seq.sv
module ring_walk_seq
    import ring_walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          resume,
    input  logic [AW-1:0] start_addr,
    input  logic          rx_mode,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          done,
    output logic          empty,
    output logic          idle,
    output logic          acc_clear,
    output logic          acc_take,
    output logic [LW-1:0] acc_allow,
    input  logic [LW-1:0] acc_count,
    input  logic          acc_trunc,
    input  logic          acc_room
);
    walk_st_e      st;
    desc_t         d;
    logic [AW-1:0] cur;
    logic [1:0]    idx;
    logic [LW-1:0] cnt;
    logic          rx_q;
    logic [LW-1:0] nwords;
    logic [7:0]    flags_out;

    assign nwords    = word_count(d.len);
    assign acc_allow = d.allow;
    assign acc_clear = (st == ST_CATCH) && (idx == 2'd3);
    assign acc_take  = (st == ST_RXIN) && rx_valid;
    assign rx_ready  = (st == ST_RXIN);
    assign idle      = (st == ST_IDLE);
    assign empty     = (st == ST_CATCH) && (idx == 2'd0) && !mem_rdata[FLG_OWN];
    assign done      = (st == ST_PUTFLG) && d.flags[FLG_IRQ];
    assign tx_valid  = (st == ST_TXOUT);
    assign tx_data   = mem_rdata;
    assign tx_last   = tx_valid && (cnt + 16'd1 == nwords);

    always_comb begin
        flags_out          = d.flags;
        flags_out[FLG_OWN] = 1'b0;
        if (rx_q && acc_trunc) flags_out[FLG_OVR] = 1'b1;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        case (st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur + {27'b0, field_off(idx)};
            end
            ST_TXRD: begin
                mem_req  = 1'b1;
                mem_addr = d.bufp + {14'b0, cnt, 2'b00};
            end
            ST_RXIN: begin
                if (rx_valid && acc_room) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = d.bufp + {16'b0, acc_count};
                    mem_wdata = rx_data;
                end
            end
            ST_PUTLEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + {27'b0, OFF_LEN};
                mem_wdata = {16'b0, acc_count};
            end
            ST_PUTFLG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {d.allow, 8'h00, flags_out};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            d    <= '0;
            cur  <= '0;
            idx  <= '0;
            cnt  <= '0;
            rx_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    idx <= '0;
                    if (start) begin
                        cur  <= start_addr & ALIGN_MASK;
                        rx_q <= rx_mode;
                        st   <= ST_FETCH;
                    end else if (resume) begin
                        st <= ST_FETCH;
                    end
                end
                ST_FETCH: st <= ST_CATCH;
                ST_CATCH: begin
                    cnt <= '0;
                    case (idx)
                        2'd0: begin
                            d.flags <= mem_rdata[7:0];
                            d.allow <= mem_rdata[31:16];
                        end
                        2'd1:    d.next <= mem_rdata;
                        2'd2:    d.bufp <= mem_rdata;
                        default: d.len  <= mem_rdata[15:0];
                    endcase
                    if (idx == 2'd0 && !mem_rdata[FLG_OWN]) begin
                        st <= ST_IDLE;
                    end else if (idx == 2'd3) begin
                        if (rx_q) st <= ST_RXIN;
                        else if (word_count(mem_rdata[15:0]) == '0) st <= ST_PUTFLG;
                        else st <= ST_TXRD;
                    end else begin
                        idx <= idx + 2'd1;
                        st  <= ST_FETCH;
                    end
                end
                ST_TXRD: st <= ST_TXOUT;
                ST_TXOUT: begin
                    cnt <= cnt + 16'd1;
                    st  <= (cnt + 16'd1 == nwords) ? ST_PUTFLG : ST_TXRD;
                end
                ST_RXIN: if (rx_valid && rx_last) st <= ST_PUTLEN;
                ST_PUTLEN: st <= ST_PUTFLG;
                ST_PUTFLG: begin
                    cur <= d.next & ALIGN_MASK;
                    idx <= '0;
                    st  <= ST_FETCH;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);
    p_empty_then_idle_r3: assert property (@(posedge clk) disable iff (rst)
        empty |=> idle);
    p_tx_last_in_word_r4: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid && !rx_ready);
    p_done_releases_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_req && mem_we && (mem_addr == cur) && !mem_wdata[FLG_OWN]);
    p_len_before_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PUTFLG && rx_q) |-> $past(st) == ST_PUTLEN);
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mem_req && !tx_valid && !rx_ready);
endmodule

// File: rtl/ring_walker.sv
module ring_walker
    import ring_walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          resume,
    input  logic [AW-1:0] start_addr,
    input  logic          rx_mode,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    output logic          rx_ready,
    output logic          done,
    output logic          empty,
    output logic          idle
);
    logic          acc_clear;
    logic          acc_take;
    logic [LW-1:0] acc_allow;
    logic [LW-1:0] acc_count;
    logic          acc_trunc;
    logic          acc_room;

    ring_walk_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .resume     (resume),
        .start_addr (start_addr),
        .rx_mode    (rx_mode),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_ready   (rx_ready),
        .done       (done),
        .empty      (empty),
        .idle       (idle),
        .acc_clear  (acc_clear),
        .acc_take   (acc_take),
        .acc_allow  (acc_allow),
        .acc_count  (acc_count),
        .acc_trunc  (acc_trunc),
        .acc_room   (acc_room)
    );

    ring_walk_rx_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (acc_clear),
        .take  (acc_take),
        .allow (acc_allow),
        .count (acc_count),
        .trunc (acc_trunc),
        .room  (acc_room)
    );
endmodule

// File: tb/test_ring_walker.sv
module test_ring_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, resume = 1'b0, rx_mode = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last, rx_ready, done, empty, idle;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [31:0] rx_data = '0;

    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [31:0] tb_a = '0, tb_d = '0;

    int checks = 0, errors = 0;
    int txn = 0, dones = 0, empties = 0;
    logic [31:0] txq [0:63];
    logic        txl [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_walker i_ring_walker (
        .clk(clk), .rst(rst), .start(start), .resume(resume),
        .start_addr(start_addr), .rx_mode(rx_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .done(done), .empty(empty), .idle(idle)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_a[9:2]] <= tb_d;
        else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid) begin
                txq[txn & 63] = tx_data;
                txl[txn & 63] = tx_last;
                txn = txn + 1;
            end
            if (done)  dones = dones + 1;
            if (empty) empties = empties + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        tb_we = 1'b1; tb_a = a; tb_d = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [7:0] fl, input logic [15:0] allow,
                            input logic [31:0] nxt, input logic [31:0] bufp, input logic [15:0] len);
        poke(base,      {allow, 8'h00, fl});
        poke(base + 8,  nxt);
        poke(base + 16, bufp);
        poke(base + 20, {16'h0000, len});
    endtask

    task automatic kick(input logic [31:0] a, input logic rx);
        start_addr = a; rx_mode = rx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!idle && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!idle) chk("idle timeout", 32'd0, 32'd1);
    endtask

    task automatic rx_send(input int n);
        for (int k = 0; k < n; k++) begin
            while (!rx_ready) @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 32'hC000_0000 + k;
            rx_last  = (k == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, d0, e0, exp_n, exp_len, exp_wr, a, nw;
        logic err;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 idle", {31'b0, idle}, 32'd1);
        chk("R1 quiet", {27'b0, mem_req, tx_valid, rx_ready, done, empty}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after release", {31'b0, idle}, 32'd1);

        // chain: 0x40 (len 10, irq) -> 0x80 (len 0) -> 0xC0 (not owned)
        put_desc(32'h40, 8'h81, 16'h1234, 32'h85, 32'h200, 16'd10);
        put_desc(32'h80, 8'h01, 16'h0000, 32'hC0, 32'h240, 16'd0);
        put_desc(32'hC0, 8'h80, 16'h0000, 32'h40, 32'h280, 16'd4);
        for (int k = 0; k < 4; k++) poke(32'h200 + 4*k, 32'hA000_0200 + 4*k);
        poke(32'h280, 32'hA000_0280);
        t0 = txn; d0 = dones; e0 = empties;
        kick(32'h43, 1'b0);                       // R2: low bits of start dropped
        wait_idle();
        chk("R4 word count", txn - t0, 3);
        for (int k = 0; k < 3; k++) begin
            chk("R4 word data", txq[(t0 + k) & 63], 32'hA000_0200 + 4*k);
            chk("R4 last flag", {31'b0, txl[(t0 + k) & 63]}, (k == 2) ? 32'd1 : 32'd0);
        end
        chk("R6 done count", dones - d0, 1);
        chk("R3 empty count", empties - e0, 1);
        chk("R5 flags write-back", mem[16], 32'h1234_0080);
        chk("R7 second desc reached", mem[32], 32'h0000_0000);
        chk("R3 unowned untouched", mem[48], 32'h0000_0080);

        // R3: resume re-reads the held descriptor
        poke(32'hC0, 32'h0000_0081);
        t0 = txn; d0 = dones; e0 = empties;
        resume = 1'b1; @(negedge clk); resume = 1'b0;
        wait_idle();
        chk("R3 resume words", txn - t0, 1);
        chk("R3 resume data", txq[t0 & 63], 32'hA000_0280);
        chk("R6 resume done", dones - d0, 1);
        chk("R3 resume empty", empties - e0, 1);
        chk("R5 resumed released", mem[48], 32'h0000_0080);

        // R4/R6: transmit length sweep, no completion request
        for (int len = 0; len <= 12; len++) begin
            put_desc(32'h40, 8'h01, 16'h0000, 32'h80, 32'h200, len[15:0]);
            poke(32'h80, 32'h0);
            t0 = txn; d0 = dones;
            kick(32'h40, 1'b0);
            wait_idle();
            exp_n = (len + 3) / 4;
            chk("R4 sweep count", txn - t0, exp_n);
            for (int k = 0; k < exp_n; k++) begin
                chk("R4 sweep data", txq[(t0 + k) & 63], 32'hA000_0200 + 4*k);
                chk("R4 sweep last", {31'b0, txl[(t0 + k) & 63]}, (k == exp_n - 1) ? 32'd1 : 32'd0);
            end
            chk("R6 no request no done", dones - d0, 0);
            chk("R5 sweep flags", mem[16], 32'h0000_0000);
        end

        // R8: basic receive
        for (int k = 0; k < 4; k++) poke(32'h300 + 4*k, 32'hDEAD_0000 + k);
        put_desc(32'h100, 8'h81, 16'd12, 32'h80, 32'h300, 16'h00FF);
        poke(32'h80, 32'h0);
        d0 = dones;
        kick(32'h100, 1'b1);
        rx_send(2);
        wait_idle();
        chk("R8 length word", mem[69], 32'd8);
        chk("R5 rx flags", mem[64], 32'h000C_0080);
        chk("R8 buffer word 0", mem[192], 32'hC000_0000);
        chk("R8 buffer word 1", mem[193], 32'hC000_0001);
        chk("R8 beyond untouched", mem[194], 32'hDEAD_0002);
        chk("R6 rx done", dones - d0, 1);

        // R9: allowance and word-count sweep
        for (a = 0; a <= 12; a++) begin
            for (nw = 1; nw <= 4; nw++) begin
                for (int k = 0; k < 4; k++) poke(32'h300 + 4*k, 32'hDEAD_0000 + k);
                put_desc(32'h100, 8'h01, a[15:0], 32'h80, 32'h300, 16'h0);
                kick(32'h100, 1'b1);
                rx_send(nw);
                wait_idle();
                exp_len = (4*nw < a) ? 4*nw : a;
                err = (4*nw > a);
                chk("R9 length", mem[69], exp_len);
                chk("R9 flags", mem[64], {a[15:0], 8'h00, 5'b0, err, 2'b00});
                for (int k = 0; k < 4; k++) begin
                    exp_wr = (k < nw) && (4*k < a);
                    chk("R9 buffer", mem[192 + k], exp_wr ? 32'hC000_0000 + k : 32'hDEAD_0000 + k);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule